// File: doc/BRIEF.md
# Serial peripheral register front end

This block sits between a processor and the byte serialiser of a simple serial peripheral. The processor reaches it through a small memory-mapped bus: a 2-bit address, separate read and write strobes, write data, and read data that is valid in the same cycle as the read strobe. Four locations are decoded. Location 0 is a read-only status word. Location 1 is a write-only acknowledge word. Location 2 is a write-only outgoing byte holder. Location 3 is a read-only incoming byte holder.

Toward the line side, the outgoing holder presents its byte on a valid/ready stream, and the serialiser takes it. Incoming bytes arrive on a second stream whose valid marks a byte that cannot be stalled. The front end raises `rx_ready` only while its holder is empty. Status bit 0 (outgoing space) and bit 1 (incoming data) follow buffer traffic and clear as a side effect of the matching bus access. Bit 2 (outgoing underrun) and bit 3 (incoming overrun) are sticky error flags. Writing a 1 to the same bit position of location 1 clears any of the four flags. When a hardware event sets a flag in the same cycle that software clears it, the set wins.

Top module: `serial_reg_front`

## Requirements
- R1: A synchronous active-high reset empties both holders: status reads 0x01, `tx_valid` is 0 and `rx_ready` is 1.
- R2: A read of location 0 returns the four flags in bits 3:0 with zero above them. Reads of locations 1 and 2 return 0. Writes to locations 0 and 3 change no flag and no holder. With no read strobe, read data is 0.
- R3: A write to location 2 loads the byte. From the next cycle `tx_valid` is 1, `tx_data` equals the byte and status bit 0 is 0.
- R4: A cycle with `tx_valid` and `tx_ready` both high hands the byte over. Afterwards `tx_valid` is 0 and status bit 0 is 1.
- R5: An incoming byte that arrives while the incoming holder is empty is stored. Afterwards status bit 1 is 1 and `rx_ready` is 0.
- R6: A read of location 3 returns the held byte in the same cycle. Afterwards status bit 1 is 0 and `rx_ready` is 1.
- R7: `tx_ready` high while the outgoing holder is empty sets status bit 2. The bit stays set until location 1 is written with bit 2 at 1.
- R8: An incoming byte that arrives while the holder is full and is not being read sets status bit 3, which is sticky. The new byte is dropped, and the old byte is kept.
- R9: A write to location 1 clears each status flag whose data bit is 1. Data bits at 0 leave their flags unchanged. Clearing bit 0 or bit 1 does not change holder occupancy.
- R10: When a hardware set event and a location 1 clear hit the same flag in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Location select: 0 status, 1 acknowledge, 2 outgoing byte, 3 incoming byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as `bus_rd` |
| tx_valid | output | 1 | Outgoing holder has a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Serialiser takes or requests a byte |
| rx_valid | input | 1 | Incoming byte present this cycle |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Incoming holder is empty |

## Verification
The assertions check on every cycle the following rules: an outgoing load raises `tx_valid` with the written byte, a handoff empties the holder and sets bit 0, an accepted incoming byte sets bit 1 and drops `rx_ready`, an underrun or overrun sets its error flag, error flags persist until acknowledged, and write-only locations read as zero. Some behaviour shows up only in the bench's scenarios, because it depends on what software sees across a sequence of accesses. This covers the reset value seen through a status read, the kept old byte after an overrun, the same-cycle return of the incoming byte, writes to read-only locations leaving state untouched, zero bits in an acknowledge write having no effect, and the same-cycle race between a hardware set and an acknowledge clear.

// File: rtl/serial_reg_front_pkg.sv
package serial_reg_front_pkg;

    localparam int ADDR_W = 2;
    localparam int NFLAG  = 4;

    typedef enum logic [ADDR_W-1:0] {
        LOC_STATUS = 2'd0,
        LOC_ACK    = 2'd1,
        LOC_TXHOLD = 2'd2,
        LOC_RXHOLD = 2'd3
    } loc_e;

    localparam int FL_TXSPACE = 0;
    localparam int FL_RXDATA  = 1;
    localparam int FL_UNDER   = 2;
    localparam int FL_OVER    = 3;

    localparam logic [NFLAG-1:0] FLAG_RESET = 4'b0001;

    typedef struct packed {
        logic ack_wr;
        logic tx_wr;
        logic rx_rd;
    } strobe_t;

    typedef struct packed {
        logic [NFLAG-1:0] set;
        logic [NFLAG-1:0] clr;
    } flag_evt_t;

    function automatic logic [NFLAG-1:0] ack_mask(input logic en,
                                                  input logic [NFLAG-1:0] bits);
        return en ? bits : '0;
    endfunction

endpackage

// File: rtl/serial_reg_front_decode.sv
module serial_reg_front_decode
    import serial_reg_front_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output strobe_t           strb
);
    loc_e loc;

    always_comb begin
        loc         = loc_e'(addr);
        strb        = '0;
        strb.ack_wr = wr && (loc == LOC_ACK);
        strb.tx_wr  = wr && (loc == LOC_TXHOLD);
        strb.rx_rd  = rd && (loc == LOC_RXHOLD);
    end
endmodule

// File: rtl/serial_reg_front_tx.sv
module serial_reg_front_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              handoff,
    output logic              underrun
);
    always_comb begin
        handoff  = full && take;
        underrun = take && !full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (load) begin
                full <= 1'b1;
                data <= load_data;
            end else if (handoff) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_reg_front_rx.sv
module serial_reg_front_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arrive,
    input  logic [DATA_W-1:0] arrive_data,
    input  logic              drain,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              accept,
    output logic              overrun
);
    always_comb begin
        accept  = arrive && (!full || drain);
        overrun = arrive && full && !drain;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (accept) begin
                full <= 1'b1;
                data <= arrive_data;
            end else if (drain) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_reg_front_flags.sv
module serial_reg_front_flags
    import serial_reg_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  flag_evt_t        evt,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= FLAG_RESET[i];
            else if (evt.set[i])
                flags[i] <= 1'b1;
            else if (evt.clr[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
    import serial_reg_front_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready
);
    localparam int PAD_W = DATA_W - NFLAG;

    strobe_t          strb;
    flag_evt_t        evt;
    logic [NFLAG-1:0] flags_q;
    logic             tx_full, tx_handoff, tx_under;
    logic             rx_full, rx_accept, rx_over;
    logic [DATA_W-1:0] rx_byte;

    serial_reg_front_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .strb (strb)
    );

    serial_reg_front_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (strb.tx_wr),
        .load_data (bus_wdata),
        .take      (tx_ready),
        .full      (tx_full),
        .data      (tx_data),
        .handoff   (tx_handoff),
        .underrun  (tx_under)
    );

    serial_reg_front_rx #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .arrive      (rx_valid),
        .arrive_data (rx_data),
        .drain       (strb.rx_rd),
        .full        (rx_full),
        .data        (rx_byte),
        .accept      (rx_accept),
        .overrun     (rx_over)
    );

    always_comb begin
        evt                 = '0;
        evt.set[FL_TXSPACE] = tx_handoff && !strb.tx_wr;
        evt.set[FL_RXDATA]  = rx_accept;
        evt.set[FL_UNDER]   = tx_under;
        evt.set[FL_OVER]    = rx_over;
        evt.clr             = ack_mask(strb.ack_wr, bus_wdata[NFLAG-1:0]);
        evt.clr[FL_TXSPACE] = evt.clr[FL_TXSPACE] | strb.tx_wr;
        evt.clr[FL_RXDATA]  = evt.clr[FL_RXDATA]  | strb.rx_rd;
    end

    serial_reg_front_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .flags (flags_q)
    );

    always_comb begin
        tx_valid  = tx_full;
        rx_ready  = !rx_full;
        bus_rdata = '0;
        if (bus_rd) begin
            case (loc_e'(bus_addr))
                LOC_STATUS: bus_rdata = {{PAD_W{1'b0}}, flags_q};
                LOC_RXHOLD: bus_rdata = rx_byte;
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/serial_reg_front_chk.sv
module serial_reg_front_chk
    import serial_reg_front_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [NFLAG-1:0]  status
);
    logic txw, ackw, rxr;
    assign txw  = bus_wr && bus_addr == 2'd2;
    assign ackw = bus_wr && bus_addr == 2'd1;
    assign rxr  = bus_rd && bus_addr == 2'd3;

    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
        txw |=> tx_valid && tx_data == $past(bus_wdata) && !status[0]); // R3
    AST_TX_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !txw) |=> !tx_valid && status[0]); // R4
    AST_RX_STORE: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready) |=> !rx_ready && status[1]); // R5
    AST_UNDER_SET: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_valid) |=> status[2]); // R7
    AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[2] && !(ackw && bus_wdata[2])) |=> status[2]); // R7
    AST_OVER_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready && !rxr) |=> status[3] && !rx_ready); // R8
    AST_OVER_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[3] && !(ackw && bus_wdata[3])) |=> status[3]); // R8
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == 2'd1 || bus_addr == 2'd2)) |-> bus_rdata == '0); // R2
endmodule

bind serial_reg_front serial_reg_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .status    (flags_q)
);

// File: tb/serial_reg_front_test.sv
`timescale 1ns/1ps
module serial_reg_front_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       tx_valid, tx_ready;
    logic [7:0] tx_data;
    logic       rx_valid, rx_ready;
    logic [7:0] rx_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    serial_reg_front uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_status(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        bus_read(2'd0, v);
        check(tag, v, exp);
    endtask

    task automatic pulse_tx_ready();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
        check("R1 rx_ready", {7'd0, rx_ready}, 8'h01);
        expect_status("R1 status", 8'h01);
    endtask

    task automatic t_tx_path();
        bus_write(2'd2, 8'hA5);
        check("R3 tx_valid", {7'd0, tx_valid}, 8'h01);
        check("R3 tx_data", tx_data, 8'hA5);
        expect_status("R3 status", 8'h00);
        pulse_tx_ready();
        check("R4 tx_valid", {7'd0, tx_valid}, 8'h00);
        expect_status("R4 status", 8'h01);
    endtask

    task automatic t_map();
        logic [7:0] v;
        bus_write(2'd0, 8'hFF);
        bus_write(2'd3, 8'h55);
        expect_status("R2 status after ignored writes", 8'h01);
        check("R2 rx_ready after ignored write", {7'd0, rx_ready}, 8'h01);
        bus_read(2'd1, v);
        check("R2 ack reads zero", v, 8'h00);
        bus_read(2'd2, v);
        check("R2 txhold reads zero", v, 8'h00);
        #1 check("R2 idle rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_rx_path();
        logic [7:0] v;
        send_rx(8'h3C);
        check("R5 rx_ready", {7'd0, rx_ready}, 8'h00);
        expect_status("R5 status", 8'h03);
        bus_read(2'd3, v);
        check("R6 rx byte", v, 8'h3C);
        check("R6 rx_ready", {7'd0, rx_ready}, 8'h01);
        expect_status("R6 status", 8'h01);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send_rx(8'h11);
        send_rx(8'h22);
        expect_status("R8 status", 8'h0B);
        bus_read(2'd3, v);
        check("R8 old byte kept", v, 8'h11);
        expect_status("R8 sticky after read", 8'h09);
        bus_write(2'd1, 8'h08);
        expect_status("R9 overrun cleared", 8'h01);
    endtask

    task automatic t_underrun();
        pulse_tx_ready();
        expect_status("R7 status", 8'h05);
        repeat (3) @(negedge clk);
        expect_status("R7 sticky", 8'h05);
        bus_write(2'd1, 8'h00);
        expect_status("R9 zero write no effect", 8'h05);
        bus_write(2'd1, 8'h04);
        expect_status("R9 underrun cleared", 8'h01);
    endtask

    task automatic t_ack_low_bits();
        bus_write(2'd1, 8'h01);
        expect_status("R9 space flag cleared", 8'h00);
        check("R9 tx occupancy unchanged", {7'd0, tx_valid}, 8'h00);
        bus_write(2'd2, 8'h77);
        pulse_tx_ready();
        expect_status("R4 space flag restored", 8'h01);
        send_rx(8'h44);
        bus_write(2'd1, 8'h02);
        expect_status("R9 data flag cleared", 8'h01);
        check("R9 rx occupancy unchanged", {7'd0, rx_ready}, 8'h00);
        begin
            logic [7:0] v;
            bus_read(2'd3, v);
            check("R9 rx byte still held", v, 8'h44);
        end
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        tx_ready = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h04; bus_wr = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0; bus_wr = 1'b0;
        expect_status("R10 underrun set wins", 8'h05);
        bus_write(2'd1, 8'h04);
        send_rx(8'h01);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h02; bus_addr = 2'd1; bus_wdata = 8'h08; bus_wr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; bus_wr = 1'b0;
        expect_status("R10 overrun set wins", 8'h0B);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        tx_ready = 0; rx_valid = 0; rx_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_path();
        t_map();
        t_rx_path();
        t_overrun();
        t_underrun();
        t_ack_low_bits();
        t_set_wins();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule